// File: doc/BRIEF.md
# Parse Round Action Sequencer

This block runs one round of a packet parser. A round has four steps: the parse-graph action and three ALU slots. A 2-bit priority code decides where the action falls among the ALUs. Each ALU step raises a request to its slot and waits for that slot's done signal, then stages the result the slot presents. The action step takes one cycle and stages the next program counter and the next parse node.

No staged value reaches the register file until every step has run. All staged register, flag and error updates are then applied together in one commit cycle. After the commit, the header offset can be moved by a signed step: a nonzero increment is added or subtracted, chosen by a polarity bit. Whenever the header offset is written, a small window of packet bytes starting at the new offset is reloaded. The round closes with a one-cycle done pulse and a stop flag that tells the caller whether parsing has ended.

A controller pulses `start_i` together with the priority and the action fields. It serves the ALU handshakes, then reads `stop_o` when `done_o` pulses.

Top module: `parse_round_seq`

## Requirements
- R1: After reset, all general registers, the flag word, the error word and the header window read zero, and `busy_o`, `done_o`, `stop_o` and every ALU request are low.
- R2: ALU requests are issued in slot order 0, 1, 2. At most one request is high at any time. A request stays high until its slot's done input is seen.
- R3: The priority code p (0 to 3) places the action step after exactly p ALU steps: 0 puts it first, 3 puts it last. A staged write from a step later in the round replaces the same register's write from an earlier step.
- R4: Within a round, a later staged write to a register replaces an earlier one. A later flag or error value replaces an earlier one only on the bits its mask selects, and earlier staged bits outside that mask are kept.
- R5: General registers, flags and errors do not change while steps are still running. All staged updates appear together after the last step.
- R6: The action stages its next-PC field into register 0 and its next-node field into register 1.
- R7: At commit, each flag or error bit whose staged mask bit is 1 takes the staged value. Every other bit keeps its old value.
- R8: Every write of the header offset (register 2) reloads the header window. Byte k of the window (bits 8k+7..8k) becomes packet byte offset+k. Packet byte j sits at `pkt_i` bits 8j+7..8j, and a byte past the end of the packet buffer reads zero.
- R9: After the commit, a nonzero increment adds to the committed header offset when the polarity is 1 and subtracts from it when the polarity is 0. A zero increment leaves the offset unchanged.
- R10: `stop_o` is 1 at the round's end if the action's last-round bit is set, or if the final header offset is greater than or equal to `pkt_len_i`. Otherwise it is 0.
- R11: `done_o` is high for exactly one cycle per round, after the commit and the offset step, and `busy_o` falls with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a round; sampled only when idle |
| prio_i | input | 2 | Position of the action among the ALU steps |
| act_next_pc_i | input | 16 | Next program counter staged by the action |
| act_next_node_i | input | 16 | Next parse node staged by the action |
| act_hinc_i | input | 8 | Header offset increment magnitude |
| act_hpol_i | input | 1 | 1 adds the increment, 0 subtracts it |
| act_last_i | input | 1 | Last-round bit |
| pkt_len_i | input | 16 | Packet length in bytes |
| pkt_i | input | 512 | Packet buffer, byte j at bits 8j+7..8j |
| alu_req_o | output | 3 | Per-slot ALU request |
| alu_done_i | input | 3 | Per-slot ALU completion |
| alu_wen_i | input | 3 | Per-slot register write enable |
| alu_widx_i | input | 9 | Per-slot 3-bit destination register index |
| alu_wdata_i | input | 48 | Per-slot 16-bit write data |
| alu_fmask_i | input | 48 | Per-slot 16-bit flag mask |
| alu_fval_i | input | 48 | Per-slot 16-bit flag values |
| alu_emask_i | input | 24 | Per-slot 8-bit error mask |
| alu_eval_i | input | 24 | Per-slot 8-bit error values |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle end-of-round pulse |
| stop_o | output | 1 | Parsing ends after this round |
| gpr_o | output | 128 | Eight 16-bit general registers, register i at bits 16i+15..16i |
| flags_o | output | 16 | Committed flag word |
| err_o | output | 8 | Committed error word |
| hv_o | output | 32 | Header window bytes |

## Verification
The assertions assume that a slot's done input is raised only while that slot's request is high, and that the action fields, the priority and the packet length stay steady once a round has started. They also assume that `start_i` is pulsed only while the block is idle. The bench drives each done input for one cycle, and only after it has seen the matching request at a falling edge. It changes no action field or packet input until the done pulse has been observed. Slot latencies differ from one another, so waiting on a request and keeping it steady are both exercised.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int GPR_W    = 16;
    localparam int NUM_GPR  = 8;
    localparam int GIDX_W   = $clog2(NUM_GPR);
    localparam int FLAG_W   = 16;
    localparam int ERR_W    = 8;
    localparam int INC_W    = 8;

    localparam int IDX_PC   = 0;
    localparam int IDX_NODE = 1;
    localparam int IDX_HO   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_COMMIT,
        ST_ADJUST,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [GPR_W-1:0] pc;
        logic [GPR_W-1:0] node;
        logic [INC_W-1:0] inc;
        logic             pol;
        logic             last;
    } action_t;

    typedef struct packed {
        logic              wen;
        logic [GIDX_W-1:0] idx;
        logic [GPR_W-1:0]  data;
        logic [FLAG_W-1:0] fmask;
        logic [FLAG_W-1:0] fval;
        logic [ERR_W-1:0]  emask;
        logic [ERR_W-1:0]  eval;
    } alu_res_t;

    function automatic logic [FLAG_W-1:0] merge_flags(
        input logic [FLAG_W-1:0] old_v,
        input logic [FLAG_W-1:0] mask,
        input logic [FLAG_W-1:0] new_v
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [ERR_W-1:0] merge_errs(
        input logic [ERR_W-1:0] old_v,
        input logic [ERR_W-1:0] mask,
        input logic [ERR_W-1:0] new_v
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/psq_step_order.sv
module psq_step_order #(
    parameter int NUM_ALU = 3,
    parameter int STEP_W  = $clog2(NUM_ALU + 1),
    parameter int SEL_W   = (NUM_ALU > 1) ? $clog2(NUM_ALU) : 1
) (
    input  logic [STEP_W-1:0] prio_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              is_act_o,
    output logic [SEL_W-1:0]  alu_sel_o
);

    logic [STEP_W-1:0] alu_step;

    always_comb begin
        is_act_o = (step_i == prio_i);
        if (step_i < prio_i) begin
            alu_step = step_i;
        end else begin
            alu_step = step_i - STEP_W'(1);
        end
        alu_sel_o = SEL_W'(alu_step);
    end

endmodule

// File: rtl/psq_stage_buf.sv
module psq_stage_buf
    import psq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_i,
    input  logic                      act_stage_i,
    input  logic [GPR_W-1:0]          act_pc_i,
    input  logic [GPR_W-1:0]          act_node_i,
    input  logic                      alu_stage_i,
    input  alu_res_t                  alu_res_i,
    output logic [NUM_GPR-1:0]        upd_o,
    output logic [NUM_GPR*GPR_W-1:0]  val_o,
    output logic [FLAG_W-1:0]         fmask_o,
    output logic [FLAG_W-1:0]         fval_o,
    output logic [ERR_W-1:0]          emask_o,
    output logic [ERR_W-1:0]          eval_o
);

    logic [NUM_GPR-1:0] upd_q;
    logic [GPR_W-1:0]   val_q [NUM_GPR];
    logic [FLAG_W-1:0]  fmask_q;
    logic [FLAG_W-1:0]  fval_q;
    logic [ERR_W-1:0]   emask_q;
    logic [ERR_W-1:0]   eval_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            upd_q   <= '0;
            fmask_q <= '0;
            fval_q  <= '0;
            emask_q <= '0;
            eval_q  <= '0;
            for (int i = 0; i < NUM_GPR; i++) begin
                val_q[i] <= '0;
            end
        end else if (act_stage_i) begin
            upd_q[IDX_PC]   <= 1'b1;
            upd_q[IDX_NODE] <= 1'b1;
            val_q[IDX_PC]   <= act_pc_i;
            val_q[IDX_NODE] <= act_node_i;
        end else if (alu_stage_i) begin
            if (alu_res_i.wen) begin
                upd_q[alu_res_i.idx] <= 1'b1;
                val_q[alu_res_i.idx] <= alu_res_i.data;
            end
            fmask_q <= fmask_q | alu_res_i.fmask;
            fval_q  <= merge_flags(fval_q, alu_res_i.fmask, alu_res_i.fval);
            emask_q <= emask_q | alu_res_i.emask;
            eval_q  <= merge_errs(eval_q, alu_res_i.emask, alu_res_i.eval);
        end
    end

    generate
        for (genvar g = 0; g < NUM_GPR; g++) begin : g_flat
            assign val_o[g*GPR_W +: GPR_W] = val_q[g];
        end
    endgenerate

    assign upd_o   = upd_q;
    assign fmask_o = fmask_q;
    assign fval_o  = fval_q;
    assign emask_o = emask_q;
    assign eval_o  = eval_q;

endmodule

// File: rtl/psq_regfile.sv
module psq_regfile
    import psq_pkg::*;
#(
    parameter int PKT_BYTES = 64,
    parameter int HV_BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit_i,
    input  logic [NUM_GPR-1:0]        upd_i,
    input  logic [NUM_GPR*GPR_W-1:0]  val_i,
    input  logic [FLAG_W-1:0]         fmask_i,
    input  logic [FLAG_W-1:0]         fval_i,
    input  logic [ERR_W-1:0]          emask_i,
    input  logic [ERR_W-1:0]          eval_i,
    input  logic                      adj_i,
    input  logic [INC_W-1:0]          hinc_i,
    input  logic                      hpol_i,
    input  logic [PKT_BYTES*8-1:0]    pkt_i,
    output logic [NUM_GPR*GPR_W-1:0]  gpr_o,
    output logic [FLAG_W-1:0]         flags_o,
    output logic [ERR_W-1:0]          err_o,
    output logic [HV_BYTES*8-1:0]     hv_o,
    output logic [GPR_W-1:0]          ho_next_o
);

    logic [GPR_W-1:0]      gpr_q [NUM_GPR];
    logic [FLAG_W-1:0]     flags_q;
    logic [ERR_W-1:0]      err_q;
    logic [HV_BYTES*8-1:0] hv_q;
    logic [GPR_W-1:0]      ho_cur;
    logic [GPR_W-1:0]      ho_commit;

    function automatic logic [HV_BYTES*8-1:0] window(input logic [GPR_W-1:0] off);
        logic [HV_BYTES*8-1:0] w;
        logic [PKT_BYTES*8-1:0] sh;
        w = '0;
        for (int k = 0; k < HV_BYTES; k++) begin
            if ((int'(off) + k) < PKT_BYTES) begin
                sh = pkt_i >> (8 * (int'(off) + k));
                w[8*k +: 8] = sh[7:0];
            end
        end
        return w;
    endfunction

    assign ho_cur    = gpr_q[IDX_HO];
    assign ho_commit = val_i[IDX_HO*GPR_W +: GPR_W];

    always_comb begin
        if (hinc_i == '0) begin
            ho_next_o = ho_cur;
        end else if (hpol_i) begin
            ho_next_o = ho_cur + GPR_W'(hinc_i);
        end else begin
            ho_next_o = ho_cur - GPR_W'(hinc_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            err_q   <= '0;
            hv_q    <= '0;
            for (int i = 0; i < NUM_GPR; i++) begin
                gpr_q[i] <= '0;
            end
        end else if (commit_i) begin
            for (int i = 0; i < NUM_GPR; i++) begin
                if (upd_i[i]) begin
                    gpr_q[i] <= val_i[i*GPR_W +: GPR_W];
                end
            end
            flags_q <= merge_flags(flags_q, fmask_i, fval_i);
            err_q   <= merge_errs(err_q, emask_i, eval_i);
            if (upd_i[IDX_HO]) begin
                hv_q <= window(ho_commit);
            end
        end else if (adj_i && (hinc_i != '0)) begin
            gpr_q[IDX_HO] <= ho_next_o;
            hv_q          <= window(ho_next_o);
        end
    end

    generate
        for (genvar g = 0; g < NUM_GPR; g++) begin : g_out
            assign gpr_o[g*GPR_W +: GPR_W] = gpr_q[g];
        end
    endgenerate

    assign flags_o = flags_q;
    assign err_o   = err_q;
    assign hv_o    = hv_q;

    AST_HV_TRACKS_HO: assert property (@(posedge clk) disable iff (rst)
        (adj_i && !commit_i && hinc_i != '0) |=> (hv_o == window(gpr_o[IDX_HO*GPR_W +: GPR_W]))) // R8
        else $error("header window not reloaded after offset step");

endmodule

// File: rtl/parse_round_seq.sv
module parse_round_seq
    import psq_pkg::*;
#(
    parameter int NUM_ALU   = 3,
    parameter int PKT_BYTES = 64,
    parameter int HV_BYTES  = 4,
    parameter int PRIO_W    = $clog2(NUM_ALU + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [PRIO_W-1:0]             prio_i,
    input  logic [GPR_W-1:0]              act_next_pc_i,
    input  logic [GPR_W-1:0]              act_next_node_i,
    input  logic [INC_W-1:0]              act_hinc_i,
    input  logic                          act_hpol_i,
    input  logic                          act_last_i,
    input  logic [GPR_W-1:0]              pkt_len_i,
    input  logic [PKT_BYTES*8-1:0]        pkt_i,
    output logic [NUM_ALU-1:0]            alu_req_o,
    input  logic [NUM_ALU-1:0]            alu_done_i,
    input  logic [NUM_ALU-1:0]            alu_wen_i,
    input  logic [NUM_ALU*GIDX_W-1:0]     alu_widx_i,
    input  logic [NUM_ALU*GPR_W-1:0]      alu_wdata_i,
    input  logic [NUM_ALU*FLAG_W-1:0]     alu_fmask_i,
    input  logic [NUM_ALU*FLAG_W-1:0]     alu_fval_i,
    input  logic [NUM_ALU*ERR_W-1:0]      alu_emask_i,
    input  logic [NUM_ALU*ERR_W-1:0]      alu_eval_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          stop_o,
    output logic [NUM_GPR*GPR_W-1:0]      gpr_o,
    output logic [FLAG_W-1:0]             flags_o,
    output logic [ERR_W-1:0]              err_o,
    output logic [HV_BYTES*8-1:0]         hv_o
);

    localparam int SEL_W    = (NUM_ALU > 1) ? $clog2(NUM_ALU) : 1;
    localparam int LAST_STP = NUM_ALU;

    seq_state_e          state_q;
    logic [PRIO_W-1:0]   step_q;
    logic [PRIO_W-1:0]   prio_q;
    action_t             act_q;
    logic                stop_q;

    logic                is_act;
    logic [SEL_W-1:0]    alu_sel;
    logic                sel_done;
    logic                act_stage;
    logic                alu_stage;
    logic                advance;
    logic                commit;
    logic                adjust;
    logic                accept;
    alu_res_t            sel_res;

    logic [NUM_GPR-1:0]       pend_upd;
    logic [NUM_GPR*GPR_W-1:0] pend_val;
    logic [FLAG_W-1:0]        pend_fmask;
    logic [FLAG_W-1:0]        pend_fval;
    logic [ERR_W-1:0]         pend_emask;
    logic [ERR_W-1:0]         pend_eval;
    logic [GPR_W-1:0]         ho_next;
    logic [GPR_W-1:0]         ho_now;

    psq_step_order #(
        .NUM_ALU (NUM_ALU),
        .STEP_W  (PRIO_W),
        .SEL_W   (SEL_W)
    ) i_order (
        .prio_i    (prio_q),
        .step_i    (step_q),
        .is_act_o  (is_act),
        .alu_sel_o (alu_sel)
    );

    always_comb begin
        sel_res.wen   = alu_wen_i[alu_sel];
        sel_res.idx   = alu_widx_i[alu_sel*GIDX_W +: GIDX_W];
        sel_res.data  = alu_wdata_i[alu_sel*GPR_W +: GPR_W];
        sel_res.fmask = alu_fmask_i[alu_sel*FLAG_W +: FLAG_W];
        sel_res.fval  = alu_fval_i[alu_sel*FLAG_W +: FLAG_W];
        sel_res.emask = alu_emask_i[alu_sel*ERR_W +: ERR_W];
        sel_res.eval  = alu_eval_i[alu_sel*ERR_W +: ERR_W];
    end

    assign sel_done  = alu_done_i[alu_sel];
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign act_stage = (state_q == ST_RUN) && is_act;
    assign alu_stage = (state_q == ST_RUN) && !is_act && sel_done;
    assign advance   = act_stage || alu_stage;
    assign commit    = (state_q == ST_COMMIT);
    assign adjust    = (state_q == ST_ADJUST);

    generate
        for (genvar g = 0; g < NUM_ALU; g++) begin : g_req
            assign alu_req_o[g] = (state_q == ST_RUN) && !is_act && (alu_sel == SEL_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            prio_q  <= '0;
            act_q   <= '0;
            stop_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_RUN;
                        step_q     <= '0;
                        prio_q     <= prio_i;
                        act_q.pc   <= act_next_pc_i;
                        act_q.node <= act_next_node_i;
                        act_q.inc  <= act_hinc_i;
                        act_q.pol  <= act_hpol_i;
                        act_q.last <= act_last_i;
                        stop_q     <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (advance) begin
                        if (step_q == PRIO_W'(LAST_STP)) begin
                            state_q <= ST_COMMIT;
                        end else begin
                            step_q <= step_q + PRIO_W'(1);
                        end
                    end
                end
                ST_COMMIT: begin
                    state_q <= ST_ADJUST;
                end
                ST_ADJUST: begin
                    stop_q  <= act_q.last || (ho_next >= pkt_len_i);
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    psq_stage_buf i_stage (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (accept),
        .act_stage_i (act_stage),
        .act_pc_i    (act_q.pc),
        .act_node_i  (act_q.node),
        .alu_stage_i (alu_stage),
        .alu_res_i   (sel_res),
        .upd_o       (pend_upd),
        .val_o       (pend_val),
        .fmask_o     (pend_fmask),
        .fval_o      (pend_fval),
        .emask_o     (pend_emask),
        .eval_o      (pend_eval)
    );

    psq_regfile #(
        .PKT_BYTES (PKT_BYTES),
        .HV_BYTES  (HV_BYTES)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (commit),
        .upd_i     (pend_upd),
        .val_i     (pend_val),
        .fmask_i   (pend_fmask),
        .fval_i    (pend_fval),
        .emask_i   (pend_emask),
        .eval_i    (pend_eval),
        .adj_i     (adjust),
        .hinc_i    (act_q.inc),
        .hpol_i    (act_q.pol),
        .pkt_i     (pkt_i),
        .gpr_o     (gpr_o),
        .flags_o   (flags_o),
        .err_o     (err_o),
        .hv_o      (hv_o),
        .ho_next_o (ho_next)
    );

    assign ho_now = gpr_o[IDX_HO*GPR_W +: GPR_W];
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
    assign stop_o = stop_q;

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alu_req_o)) // R2
        else $error("more than one ALU request high");

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ((alu_req_o != '0) && ((alu_req_o & alu_done_i) == '0)) |=> (alu_req_o == $past(alu_req_o))) // R2
        else $error("ALU request dropped before done");

    AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> ($stable(gpr_o) && $stable(flags_o) && $stable(err_o))) // R5
        else $error("architectural state changed mid-round");

    AST_HO_ADD: assert property (@(posedge clk) disable iff (rst)
        (adjust && act_q.inc != '0 && act_q.pol) |=> (ho_now == $past(ho_now) + GPR_W'($past(act_q.inc)))) // R9
        else $error("header offset add step wrong");

    AST_HO_SUB: assert property (@(posedge clk) disable iff (rst)
        (adjust && act_q.inc != '0 && !act_q.pol) |=> (ho_now == $past(ho_now) - GPR_W'($past(act_q.inc)))) // R9
        else $error("header offset subtract step wrong");

    AST_HO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (adjust && act_q.inc == '0) |=> $stable(ho_now)) // R9
        else $error("header offset moved with zero increment");

    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (rst)
        (done_o && act_q.last) |-> stop_o) // R10
        else $error("last-round bit did not stop parsing");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) // R11
        else $error("done held longer than one cycle");

endmodule

// File: tb/test_parse_round_seq.sv
module test_parse_round_seq;

    localparam int NA = 3;
    localparam int PB = 64;
    localparam int HB = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [1:0]      prio_i = '0;
    logic [15:0]     act_next_pc_i = '0;
    logic [15:0]     act_next_node_i = '0;
    logic [7:0]      act_hinc_i = '0;
    logic            act_hpol_i = 1'b0;
    logic            act_last_i = 1'b0;
    logic [15:0]     pkt_len_i = 16'd40;
    logic [PB*8-1:0] pkt_i;
    logic [NA-1:0]   alu_req_o;
    logic [NA-1:0]   alu_done_i = '0;
    logic [NA-1:0]   alu_wen_i = '0;
    logic [NA*3-1:0]  alu_widx_i = '0;
    logic [NA*16-1:0] alu_wdata_i = '0;
    logic [NA*16-1:0] alu_fmask_i = '0;
    logic [NA*16-1:0] alu_fval_i = '0;
    logic [NA*8-1:0]  alu_emask_i = '0;
    logic [NA*8-1:0]  alu_eval_i = '0;
    logic            busy_o, done_o, stop_o;
    logic [127:0]    gpr_o;
    logic [15:0]     flags_o;
    logic [7:0]      err_o;
    logic [HB*8-1:0] hv_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    parse_round_seq i_parse_round_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .prio_i(prio_i),
        .act_next_pc_i(act_next_pc_i), .act_next_node_i(act_next_node_i),
        .act_hinc_i(act_hinc_i), .act_hpol_i(act_hpol_i), .act_last_i(act_last_i),
        .pkt_len_i(pkt_len_i), .pkt_i(pkt_i),
        .alu_req_o(alu_req_o), .alu_done_i(alu_done_i), .alu_wen_i(alu_wen_i),
        .alu_widx_i(alu_widx_i), .alu_wdata_i(alu_wdata_i),
        .alu_fmask_i(alu_fmask_i), .alu_fval_i(alu_fval_i),
        .alu_emask_i(alu_emask_i), .alu_eval_i(alu_eval_i),
        .busy_o(busy_o), .done_o(done_o), .stop_o(stop_o),
        .gpr_o(gpr_o), .flags_o(flags_o), .err_o(err_o), .hv_o(hv_o)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int j = 0; j < PB; j++) pkt_i[8*j +: 8] = 8'((j * 7 + 3) & 8'hFF);
    end

    function automatic logic [15:0] reg_rd(input int i);
        return gpr_o[16*i +: 16];
    endfunction

    function automatic logic [31:0] exp_win(input int off);
        logic [31:0] w = '0;
        for (int k = 0; k < HB; k++)
            if (off + k < PB) w[8*k +: 8] = 8'(((off + k) * 7 + 3) & 8'hFF);
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_alus();
        alu_wen_i = '0; alu_widx_i = '0; alu_wdata_i = '0;
        alu_fmask_i = '0; alu_fval_i = '0; alu_emask_i = '0; alu_eval_i = '0;
    endtask

    task automatic set_alu(input int k, input bit wen, input int idx, input logic [15:0] data);
        alu_wen_i[k] = wen;
        alu_widx_i[3*k +: 3] = 3'(idx);
        alu_wdata_i[16*k +: 16] = data;
    endtask

    task automatic set_alu_fe(input int k, input logic [15:0] fm, input logic [15:0] fv,
                              input logic [7:0] em, input logic [7:0] ev);
        alu_fmask_i[16*k +: 16] = fm; alu_fval_i[16*k +: 16] = fv;
        alu_emask_i[8*k +: 8] = em;   alu_eval_i[8*k +: 8] = ev;
    endtask

    // Runs one round, serving ALU handshakes with latency equal to the slot number.
    task automatic run_round(input logic [1:0] p, input logic [15:0] pc, input logic [15:0] node,
                             input logic [7:0] inc, input bit pol, input bit last);
        logic [127:0] snap;
        int order [3];
        int n_ord = 0;
        int wcnt = 0;
        bit stable_ok = 1'b1;
        bit seen_done = 1'b0;
        @(negedge clk);
        prio_i = p; act_next_pc_i = pc; act_next_node_i = node;
        act_hinc_i = inc; act_hpol_i = pol; act_last_i = last;
        snap = gpr_o;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (done_o) begin seen_done = 1'b1; break; end
            if (alu_done_i != '0) begin
                alu_done_i = '0;
                if (gpr_o !== snap) stable_ok = 1'b0;
            end else if (alu_req_o != '0) begin
                if (gpr_o !== snap) stable_ok = 1'b0;
                for (int k = 0; k < NA; k++) begin
                    if (alu_req_o[k]) begin
                        if (wcnt == k) begin
                            if (n_ord < 3) order[n_ord] = k;
                            n_ord++;
                            alu_done_i[k] = 1'b1;
                            wcnt = 0;
                        end else begin
                            wcnt++;
                        end
                    end
                end
            end
            @(negedge clk);
        end
        chk("R11 done seen", 64'(seen_done), 64'd1);
        chk("R2 request count", 64'(n_ord), 64'd3);
        for (int k = 0; k < 3; k++) chk("R2 request order", 64'(order[k]), 64'(k));
        chk("R5 no update before commit", 64'(stable_ok), 64'd1);
        @(negedge clk);
        chk("R11 done one cycle", 64'(done_o), 64'd0);
        chk("R11 busy low after round", 64'(busy_o), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 gpr zero", 64'(gpr_o == '0), 64'd1);
        chk("R1 flags zero", 64'(flags_o), 64'd0);
        chk("R1 err zero", 64'(err_o), 64'd0);
        chk("R1 hv zero", 64'(hv_o), 64'd0);
        chk("R1 status low", 64'({busy_o, done_o, stop_o, alu_req_o}), 64'd0);
    endtask

    task automatic t_prio0();
        clear_alus();
        set_alu(0, 1, 5, 16'hAAAA);
        set_alu(1, 1, 0, 16'h0077);
        run_round(2'd0, 16'h0011, 16'h0022, 8'd0, 1'b0, 1'b0);
        chk("R3 prio0 ALU1 overrides action PC", 64'(reg_rd(0)), 64'h77);
        chk("R6 action node", 64'(reg_rd(1)), 64'h22);
        chk("R5 ALU0 write applied", 64'(reg_rd(5)), 64'hAAAA);
        chk("R10 no stop", 64'(stop_o), 64'd0);
    endtask

    task automatic t_prio3();
        clear_alus();
        set_alu(2, 1, 0, 16'h0099);
        run_round(2'd3, 16'h0033, 16'h0034, 8'd0, 1'b0, 1'b0);
        chk("R3 prio3 action overrides ALU2", 64'(reg_rd(0)), 64'h33);
        chk("R6 action node prio3", 64'(reg_rd(1)), 64'h34);
    endtask

    task automatic t_prio1();
        clear_alus();
        set_alu(0, 1, 0, 16'h0044);
        set_alu(1, 1, 1, 16'h0055);
        run_round(2'd1, 16'h0066, 16'h0067, 8'd0, 1'b0, 1'b0);
        chk("R3 prio1 action after ALU0", 64'(reg_rd(0)), 64'h66);
        chk("R3 prio1 ALU1 after action", 64'(reg_rd(1)), 64'h55);
    endtask

    task automatic t_prio2();
        clear_alus();
        set_alu(1, 1, 1, 16'h0012);
        set_alu(2, 1, 0, 16'h0013);
        run_round(2'd2, 16'h0021, 16'h0022, 8'd0, 1'b0, 1'b0);
        chk("R3 prio2 ALU2 after action", 64'(reg_rd(0)), 64'h13);
        chk("R3 prio2 action after ALU1", 64'(reg_rd(1)), 64'h22);
    endtask

    task automatic t_override();
        clear_alus();
        set_alu(0, 1, 4, 16'h0001);
        set_alu(2, 1, 4, 16'h0002);
        set_alu_fe(0, 16'h00FF, 16'h00F0, 8'h00, 8'h00);
        set_alu_fe(1, 16'h0F0F, 16'h0A0A, 8'h00, 8'h00);
        set_alu_fe(2, 16'h0000, 16'hFFFF, 8'h81, 8'h01);
        run_round(2'd0, 16'h0001, 16'h0002, 8'd0, 1'b0, 1'b0);
        chk("R4 later register write wins", 64'(reg_rd(4)), 64'h2);
        chk("R4 flag masks merge", 64'(flags_o), 64'h0AFA);
        chk("R7 error masked set", 64'(err_o), 64'h01);
        clear_alus();
        set_alu_fe(0, 16'h000F, 16'h0000, 8'h02, 8'h02);
        run_round(2'd0, 16'h0001, 16'h0002, 8'd0, 1'b0, 1'b0);
        chk("R7 unmasked flags kept", 64'(flags_o), 64'h0AF0);
        chk("R7 unmasked errors kept", 64'(err_o), 64'h03);
    endtask

    task automatic t_header();
        clear_alus();
        set_alu(0, 1, 2, 16'd10);
        run_round(2'd0, 16'h0, 16'h0, 8'd0, 1'b0, 1'b0);
        chk("R8 HO write", 64'(reg_rd(2)), 64'd10);
        chk("R8 window reload", 64'(hv_o), 64'(exp_win(10)));
        chk("R9 zero inc keeps", 64'(reg_rd(2)), 64'd10);
        clear_alus();
        run_round(2'd1, 16'h0, 16'h0, 8'd5, 1'b1, 1'b0);
        chk("R9 add step", 64'(reg_rd(2)), 64'd15);
        chk("R8 window after step", 64'(hv_o), 64'(exp_win(15)));
        run_round(2'd2, 16'h0, 16'h0, 8'd3, 1'b0, 1'b0);
        chk("R9 subtract step", 64'(reg_rd(2)), 64'd12);
        chk("R8 window after subtract", 64'(hv_o), 64'(exp_win(12)));
        chk("R10 inside packet", 64'(stop_o), 64'd0);
    endtask

    task automatic t_stop();
        clear_alus();
        set_alu(0, 1, 2, 16'd62);
        run_round(2'd0, 16'h0, 16'h0, 8'd0, 1'b0, 1'b0);
        chk("R8 window past buffer end", 64'(hv_o), 64'(exp_win(62)));
        chk("R10 offset past length stops", 64'(stop_o), 64'd1);
        set_alu(0, 1, 2, 16'd5);
        run_round(2'd3, 16'h0, 16'h0, 8'd0, 1'b0, 1'b1);
        chk("R10 last-round stops", 64'(stop_o), 64'd1);
        set_alu(0, 1, 2, 16'd30);
        run_round(2'd0, 16'h0, 16'h0, 8'd10, 1'b1, 1'b0);
        chk("R9 commit then step", 64'(reg_rd(2)), 64'd40);
        chk("R10 offset equal length stops", 64'(stop_o), 64'd1);
        run_round(2'd0, 16'h0, 16'h0, 8'd9, 1'b1, 1'b0);
        chk("R10 offset below length continues", 64'(stop_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prio0();
        t_prio3();
        t_prio1();
        t_prio2();
        t_override();
        t_header();
        t_stop();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule